// File: doc/BRIEF.md
# Shared-Bus Parallel SRAM Sequencer

This controller lets a narrow host reach a 32 K x 8 asynchronous static RAM while spending only eight data pins and four strobes. Address and data travel over the same eight-bit bus. Two external transparent eight-bit latches hold the address: one keeps the low byte and the other the upper seven bits. A single request (address, write data, direction, start) makes the controller walk a fixed phase sequence. It latches the low address byte, latches the high address byte, then either drives the data byte or releases the bus, and strobes the memory's write or output enable. It signals completion with a one-cycle `done` pulse. Read data is returned on `host_rdata`.

The bus is split into an output value, a drive enable and an input value. The pad ring, or a bench model, forms the tri-state pin from these. The state machine has eleven named states:

- `S_IDLE`
- `S_LO_SETUP`, `S_LO_STB`, `S_LO_HOLD`
- `S_HI_SETUP`, `S_HI_STB`, `S_HI_HOLD`
- `S_DAT_SETUP`, `S_OP_STB`, `S_OP_HOLD`
- `S_DONE`

Its transitions are:

- `S_IDLE` goes to `S_LO_SETUP` on `host_start`.
- Each `*_SETUP` state goes to its `*_STB` state after one cycle.
- Each `*_STB` state goes to its `*_HOLD` state when the pulse timer reports its last cycle.
- `S_LO_HOLD` goes to `S_HI_SETUP`.
- `S_HI_HOLD` goes to `S_DAT_SETUP`.
- `S_OP_HOLD` goes to `S_DONE`.
- `S_DONE` goes to `S_IDLE`.

Top module: `sram_mux_seq`

## Requirements
- R1: While reset is held and after it is released, both latch enables are low, `mem_we_n` and `mem_oe_n` are high, `mbus_drive`, `host_busy` and `host_done` are low, and `host_rdata` is 0.
- R2: An access accepted at a clock edge drives `host_addr[7:0]` on the bus from the next cycle. This is followed by `{1'b0, host_addr[14:8]}`. The low byte is captured by `alat_lo_en` strictly before the high byte is captured by `alat_hi_en`.
- R3: Each strobe lasts exactly `PULSE_CYC` cycles. Here a strobe is `alat_lo_en`, `alat_hi_en`, or `mem_we_n` / `mem_oe_n` low. For every strobe except output enable, the bus is driven with a stable value for one cycle before the strobe and one cycle after it.
- R4: For a write (`host_write`=1), the data byte is driven during the data setup, strobe and hold cycles, and `mem_we_n` pulses low while `mem_oe_n` stays high.
- R5: For a read, the bus is released from the data setup cycle through the end of the access, and `mem_oe_n` pulses low. The byte on `mbus_in` in the last output-enable cycle appears on `host_rdata` and stays until the next read completes.
- R6: Neither latch enable is ever high while `mem_oe_n` is low. The controller never drives the bus while `mem_oe_n` is low. `mem_we_n` and `mem_oe_n` are never low together.
- R7: `host_done` is a single-cycle pulse in cycle `3*PULSE_CYC+6` after acceptance, counting the first cycle after the accepting edge as cycle 0.
- R8: `host_busy` is high from the cycle after acceptance through the `host_done` cycle. A `host_start` seen while busy, including during the `host_done` cycle, is ignored.
- R9: Data written to an address reads back unchanged through the same sequence, whatever fixed permutation is applied between the high latch outputs and the memory's upper address pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_start | input | 1 | Request an access; accepted only when idle |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 15 | Memory address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Last read data |
| host_done | output | 1 | One-cycle completion pulse |
| host_busy | output | 1 | Access in progress |
| mbus_out | output | 8 | Value driven onto the shared bus |
| mbus_drive | output | 1 | Bus driver enable |
| mbus_in | input | 8 | Value seen on the shared bus |
| alat_lo_en | output | 1 | Low address latch enable (active high) |
| alat_hi_en | output | 1 | High address latch enable (active high) |
| mem_we_n | output | 1 | Memory write enable (active low) |
| mem_oe_n | output | 1 | Memory output enable (active low) |

## Verification
Two functions can fall in the same cycle:

- a new host request landing while the sequencer is still finishing the previous access;
- the completion of a read together with the capture of its data.

The bench holds `host_start` high across the `host_done` cycle and injects stray starts in the middle of accesses. A cycle-accurate timeline model then judges whether those starts are dropped and the next access begins exactly one cycle after `host_done`. Reads that follow writes through a bit-permuted memory model check that the byte captured on the last output-enable cycle is the one returned with `host_done`.

// File: rtl/sram_mux_pkg.sv
package sram_mux_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LO_SETUP,
        S_LO_STB,
        S_LO_HOLD,
        S_HI_SETUP,
        S_HI_STB,
        S_HI_HOLD,
        S_DAT_SETUP,
        S_OP_STB,
        S_OP_HOLD,
        S_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_LO,
        SEL_HI,
        SEL_DAT
    } bus_sel_t;

endpackage

// File: rtl/sram_mux_timer.sv
module sram_mux_timer #(
    parameter int PULSE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CW = (PULSE_CYC < 2) ? 1 : $clog2(PULSE_CYC);

    logic [CW-1:0] cnt;

    assign last = run && (cnt == CW'(PULSE_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (run && !last) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end
endmodule

// File: rtl/sram_mux_bus.sv
module sram_mux_bus
    import sram_mux_pkg::*;
#(
    parameter int AW = 15,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] wdata_in,
    input  logic          wr_in,
    input  bus_sel_t      sel,
    input  logic          sample,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] bus_out,
    output logic          bus_drive,
    output logic [DW-1:0] rdata,
    output logic          is_write
);
    localparam int HW  = AW - DW;
    localparam int PAD = DW - HW;

    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] hi_byte;

    generate
        if (PAD > 0) begin : g_pad
            assign hi_byte = {{PAD{1'b0}}, addr_q[AW-1:DW]};
        end else begin : g_full
            assign hi_byte = addr_q[AW-1:DW];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            is_write <= 1'b0;
        end else if (load) begin
            addr_q   <= addr_in;
            wdata_q  <= wdata_in;
            is_write <= wr_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (sample) begin
            rdata <= bus_in;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_LO:  bus_out = addr_q[DW-1:0];
            SEL_HI:  bus_out = hi_byte;
            SEL_DAT: bus_out = wdata_q;
            default: bus_out = '0;
        endcase
    end

    assign bus_drive = (sel != SEL_NONE);
endmodule

// File: rtl/sram_mux_fsm.sv
module sram_mux_fsm
    import sram_mux_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  logic     is_write,
    input  logic     pulse_last,
    output logic     pulse_run,
    output logic     load,
    output logic     sample,
    output bus_sel_t sel,
    output logic     le_lo,
    output logic     le_hi,
    output logic     we_n,
    output logic     oe_n,
    output logic     done,
    output logic     busy
);
    seq_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:      if (start) state_nx = S_LO_SETUP;
            S_LO_SETUP:  state_nx = S_LO_STB;
            S_LO_STB:    if (pulse_last) state_nx = S_LO_HOLD;
            S_LO_HOLD:   state_nx = S_HI_SETUP;
            S_HI_SETUP:  state_nx = S_HI_STB;
            S_HI_STB:    if (pulse_last) state_nx = S_HI_HOLD;
            S_HI_HOLD:   state_nx = S_DAT_SETUP;
            S_DAT_SETUP: state_nx = S_OP_STB;
            S_OP_STB:    if (pulse_last) state_nx = S_OP_HOLD;
            S_OP_HOLD:   state_nx = S_DONE;
            S_DONE:      state_nx = S_IDLE;
            default:     state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        load      = 1'b0;
        sample    = 1'b0;
        sel       = SEL_NONE;
        le_lo     = 1'b0;
        le_hi     = 1'b0;
        we_n      = 1'b1;
        oe_n      = 1'b1;
        done      = 1'b0;
        busy      = 1'b1;
        pulse_run = 1'b0;
        unique case (state)
            S_IDLE: begin
                busy = 1'b0;
                load = start;
            end
            S_LO_SETUP, S_LO_HOLD: sel = SEL_LO;
            S_LO_STB: begin
                sel       = SEL_LO;
                le_lo     = 1'b1;
                pulse_run = 1'b1;
            end
            S_HI_SETUP, S_HI_HOLD: sel = SEL_HI;
            S_HI_STB: begin
                sel       = SEL_HI;
                le_hi     = 1'b1;
                pulse_run = 1'b1;
            end
            S_DAT_SETUP, S_OP_HOLD: sel = is_write ? SEL_DAT : SEL_NONE;
            S_OP_STB: begin
                sel       = is_write ? SEL_DAT : SEL_NONE;
                we_n      = !is_write;
                oe_n      = is_write;
                pulse_run = 1'b1;
                sample    = !is_write && pulse_last;
            end
            S_DONE:  done = 1'b1;
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/sram_mux_seq.sv
module sram_mux_seq
    import sram_mux_pkg::*;
#(
    parameter int AW        = 15,
    parameter int DW        = 8,
    parameter int PULSE_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_start,
    input  logic          host_write,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_done,
    output logic          host_busy,
    output logic [DW-1:0] mbus_out,
    output logic          mbus_drive,
    input  logic [DW-1:0] mbus_in,
    output logic          alat_lo_en,
    output logic          alat_hi_en,
    output logic          mem_we_n,
    output logic          mem_oe_n
);
    logic     pulse_run, pulse_last, load, sample, is_write;
    bus_sel_t sel;

    sram_mux_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (pulse_run),
        .last  (pulse_last)
    );

    sram_mux_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (host_start),
        .is_write   (is_write),
        .pulse_last (pulse_last),
        .pulse_run  (pulse_run),
        .load       (load),
        .sample     (sample),
        .sel        (sel),
        .le_lo      (alat_lo_en),
        .le_hi      (alat_hi_en),
        .we_n       (mem_we_n),
        .oe_n       (mem_oe_n),
        .done       (host_done),
        .busy       (host_busy)
    );

    sram_mux_bus #(.AW(AW), .DW(DW)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .addr_in   (host_addr),
        .wdata_in  (host_wdata),
        .wr_in     (host_write),
        .sel       (sel),
        .sample    (sample),
        .bus_in    (mbus_in),
        .bus_out   (mbus_out),
        .bus_drive (mbus_drive),
        .rdata     (host_rdata),
        .is_write  (is_write)
    );

    // R6: separation between latch enables, output enable and the driver
    p_le_vs_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (alat_lo_en || alat_hi_en) |-> mem_oe_n);
    p_drive_vs_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mbus_drive);
    p_we_vs_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    // R3: bus held stable one cycle around every latch and write strobe
    p_lo_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alat_lo_en) |-> mbus_drive && $stable(mbus_out));
    p_lo_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alat_lo_en) |-> mbus_drive && $stable(mbus_out));
    p_hi_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alat_hi_en) |-> mbus_drive && $stable(mbus_out));
    p_hi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alat_hi_en) |-> mbus_drive && $stable(mbus_out));
    p_we_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> mbus_drive && $stable(mbus_out));
    p_we_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mbus_drive && $stable(mbus_out));

    // R7 / R8: completion pulse and busy window
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done);
    p_busy_span_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_busy && !host_done) |=> host_busy);
    p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_busy);
endmodule

// File: tb/sram_mux_seq_bench.sv
module sram_mux_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int P     = 2;
    localparam int LAST  = 3 * P + 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_start = 1'b0;
    logic        host_write = 1'b0;
    logic [14:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_done, host_busy;
    logic [7:0]  mbus_out;
    logic        mbus_drive;
    logic [7:0]  mbus_in;
    logic        alat_lo_en, alat_hi_en, mem_we_n, mem_oe_n;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sram_mux_seq #(.PULSE_CYC(P)) u_sram_mux_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_start (host_start),
        .host_write (host_write),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .host_done  (host_done),
        .host_busy  (host_busy),
        .mbus_out   (mbus_out),
        .mbus_drive (mbus_drive),
        .mbus_in    (mbus_in),
        .alat_lo_en (alat_lo_en),
        .alat_hi_en (alat_hi_en),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n)
    );

    // ---------------- external latches and permuted memory model (R9)
    logic [7:0] lat_lo = '0, lat_hi = '0;
    logic [7:0] mem [int];
    logic [7:0] sram_q;

    function automatic int phys_addr(input logic [7:0] hi, input logic [7:0] lo);
        logic [6:0] p;
        for (int i = 0; i < 7; i++) p[i] = hi[(i * 3) % 7];
        return {17'd0, p, lo};
    endfunction

    always @* begin
        if (!mem_oe_n && mem.exists(phys_addr(lat_hi, lat_lo)))
            sram_q = mem[phys_addr(lat_hi, lat_lo)];
        else
            sram_q = 8'h00;
    end

    assign mbus_in = mbus_drive ? mbus_out : (!mem_oe_n ? sram_q : 8'hFF);

    always @* if (alat_lo_en) lat_lo = mbus_in;
    always @* if (alat_hi_en) lat_hi = mbus_in;
    always @(posedge mem_we_n) if (rst_n) mem[phys_addr(lat_hi, lat_lo)] = mbus_in;

    // ---------------- timeline reference model
    logic [7:0] exp_mem [int];
    bit          m_busy = 1'b0;
    int          m_t = 0;
    logic [14:0] m_addr = '0;
    logic [7:0]  m_wd = '0;
    bit          m_wr = 1'b0;
    logic [7:0]  m_rd = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 1'b0;
            m_t    <= 0;
            m_rd   <= '0;
        end else if (!m_busy) begin
            if (host_start) begin
                m_busy <= 1'b1;
                m_t    <= 0;
                m_addr <= host_addr;
                m_wd   <= host_wdata;
                m_wr   <= host_write;
                if (host_write) exp_mem[int'(host_addr)] = host_wdata;
                else m_rd <= exp_mem.exists(int'(host_addr)) ? exp_mem[int'(host_addr)] : 8'h00;
            end
        end else if (m_t == LAST) begin
            m_busy <= 1'b0;
        end else begin
            m_t <= m_t + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h t=%0d", tag, act, exp, m_t);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            chk({alat_lo_en, alat_hi_en, mem_we_n, mem_oe_n, mbus_drive, host_busy, host_done} == 7'b0011000,
                "R1 reset outputs", {alat_lo_en, alat_hi_en, mem_we_n, mem_oe_n, mbus_drive, host_busy, host_done}, 16'b0011000);
            chk(host_rdata == 8'h00, "R1 rdata", host_rdata, 0);
        end else begin
            bit e_lo, e_hi, e_we, e_oe, e_drv, e_done;
            logic [7:0] e_bus;
            e_lo  = m_busy && m_t >= 1 && m_t <= P;
            e_hi  = m_busy && m_t >= P + 3 && m_t <= 2 * P + 2;
            e_we  = m_busy && m_wr && m_t >= 2 * P + 5 && m_t <= 3 * P + 4;
            e_oe  = m_busy && !m_wr && m_t >= 2 * P + 5 && m_t <= 3 * P + 4;
            e_done = m_busy && m_t == LAST;
            e_drv = m_busy && ((m_t <= 2 * P + 3) || (m_wr && m_t <= 3 * P + 5));
            e_bus = (m_t <= P + 1) ? m_addr[7:0] :
                    (m_t <= 2 * P + 3) ? {1'b0, m_addr[14:8]} : m_wd;
            chk(alat_lo_en == e_lo && alat_hi_en == e_hi, "R2/R3 latch strobes",
                {alat_lo_en, alat_hi_en}, {e_lo, e_hi});
            chk(mem_we_n == !e_we, "R4 write strobe", mem_we_n, !e_we);
            chk(mem_oe_n == !e_oe, "R5 read strobe", mem_oe_n, !e_oe);
            chk(mbus_drive == e_drv, "R5 bus direction", mbus_drive, e_drv);
            if (e_drv) chk(mbus_out == e_bus, "R2/R4 bus value", mbus_out, e_bus);
            chk(host_done == e_done, "R7 done timing", host_done, e_done);
            chk(host_busy == m_busy, "R8 busy window", host_busy, m_busy);
            chk(!(!mem_oe_n && (alat_lo_en || alat_hi_en || mbus_drive || !mem_we_n)),
                "R6 oe separation", {mem_oe_n, alat_lo_en, alat_hi_en, mbus_drive}, 0);
            if (!m_busy || e_done)
                chk(host_rdata == m_rd, "R5/R9 read data", host_rdata, m_rd);
        end
    end

    // ---------------- stimulus
    task automatic access(input bit wr, input logic [14:0] a, input logic [7:0] d, input bit poke);
        @(negedge clk);
        host_start = 1'b1; host_write = wr; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_start = 1'b0;
        if (poke) begin
            // R8: stray requests during an access must be ignored
            repeat (3) @(negedge clk);
            host_start = 1'b1; host_write = !wr; host_addr = ~a; host_wdata = ~d;
            @(negedge clk);
            host_start = 1'b0;
        end
        while (!host_done) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        access(1'b1, 15'h0000, 8'hA5, 1'b0);
        access(1'b1, 15'h7FFF, 8'h3C, 1'b1);
        access(1'b1, 15'h5A3C, 8'h96, 1'b0);
        access(1'b1, 15'h00FF, 8'h01, 1'b0);
        access(1'b1, 15'h7F00, 8'hFE, 1'b1);
        access(1'b0, 15'h7FFF, 8'h00, 1'b0);
        access(1'b0, 15'h0000, 8'h00, 1'b1);
        access(1'b0, 15'h5A3C, 8'h00, 1'b0);
        access(1'b0, 15'h7F00, 8'h00, 1'b0);
        access(1'b0, 15'h00FF, 8'h00, 1'b0);
        access(1'b0, 15'h1234, 8'h00, 1'b0);
        // R8: start held high across done; next access begins right after it
        @(negedge clk);
        host_start = 1'b1; host_write = 1'b1; host_addr = 15'h2AAA; host_wdata = 8'h5A;
        repeat (2 * (LAST + 2)) @(negedge clk);
        host_write = 1'b0;
        repeat (2 * (LAST + 2)) @(negedge clk);
        host_start = 1'b0;
        repeat (LAST + 4) @(negedge clk);
        access(1'b0, 15'h2AAA, 8'h00, 1'b0);
        repeat (4) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog act=hung exp=finished");
        finish_run();
    end
endmodule